// File: doc/BRIEF.md
# Packed Vector Left Shifter

This unit shifts a 64-bit or 128-bit vector operand left by one count. The operand is split into packed lanes of 16, 32 or 64 bits. Each lane shifts on its own, no bit moves from one lane into the next, and zeros enter each lane at the bottom. The count comes from one of two places. In the register forms it is a full 64-bit count operand. In the immediate forms it is an 8-bit immediate, zero-extended. A count too large for the lane size clears the whole result. It does not wrap around the lane width.

A small decoder sits in front of the datapath. It reads the secondary opcode byte, the 3-bit ModRM reg field and the operand-size prefix bit, and from these it picks the lane size, the count source and the vector width. An encoding the decoder does not recognise raises `illegal` and forces the result to zero. A single output register with a valid bit gives the unit a fixed latency of one clock. The unit has no flag outputs, so condition flags cannot change.

Top module: `vec_lshift_unit`

## Requirements
- R1: Opcode byte 0xF1 or 0x71 selects 16-bit lanes, 0xF2 or 0x72 selects 32-bit lanes, and 0xF3 or 0x73 selects 64-bit lanes. Every lane shifts independently, and no bit crosses into a neighbouring lane.
- R2: The low-order bit positions a shift vacates in each lane are filled with zeros.
- R3: If the count is at least the lane width (16, 32 or 64), every bit of the result is zero. A count one less than the lane width still shifts normally.
- R4: In the register forms (0xF1/0xF2/0xF3) the count is all 64 bits of `count_reg`. Any set bit above the lane's shift range makes the result zero.
- R5: The immediate forms (0x71/0x72/0x73) take their count from `count_imm`, zero-extended. Values 64 to 255 give a zero result for every lane size. These forms are legal only when `modrm_reg` equals 6.
- R6: `opsize_pfx`=1 selects a 128-bit vector. `opsize_pfx`=0 selects a 64-bit vector. In 64-bit mode, bits 127:64 of the result are zero and bits 127:64 of `operand` have no effect.
- R7: Any other opcode byte, or an immediate form whose `modrm_reg` is not 6, gives `illegal`=1 and a zero result.
- R8: `out_valid`, `result` and `illegal` appear one clock after the edge that samples `in_valid`=1. While `in_valid`=0, `out_valid` is 0 and `result`/`illegal` hold their values.
- R9: A synchronous active-high `rst` clears `out_valid`, `result` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| opc_byte | input | 8 | Secondary opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| opsize_pfx | input | 1 | Operand-size prefix present (128-bit vector) |
| operand | input | 128 | Vector to be shifted |
| count_reg | input | 64 | Count for register forms |
| count_imm | input | 8 | Count for immediate forms |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted vector |
| illegal | output | 1 | Unrecognised encoding |

## Verification
All three outputs come from the same output register, so each one is due exactly one clock after the rising edge that sees `in_valid` high. The bench drives inputs on the falling edge and drops `in_valid` at the next falling edge. It reads the outputs at that falling edge, half a period after the capturing edge. This keeps every read in the cycle the result belongs to. The hold and reset checks use the same half-period offset to read the register one and several cycles after the stimulus.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
  typedef enum logic [1:0] {
    LANE16 = 2'd0,
    LANE32 = 2'd1,
    LANE64 = 2'd2
  } lane_e;

  typedef struct packed {
    logic  legal;
    logic  use_imm;
    logic  wide;
    lane_e lane;
  } dec_t;

  localparam logic [7:0] OPC_R16 = 8'hF1;
  localparam logic [7:0] OPC_R32 = 8'hF2;
  localparam logic [7:0] OPC_R64 = 8'hF3;
  localparam logic [7:0] OPC_I16 = 8'h71;
  localparam logic [7:0] OPC_I32 = 8'h72;
  localparam logic [7:0] OPC_I64 = 8'h73;
  localparam logic [2:0] IMM_SUBOP = 3'd6;
  localparam int NUM_SIZES = 3;
  localparam int MIN_LANE = 16;
endpackage

// File: rtl/vshl_decode.sv
module vshl_decode
  import vshl_pkg::*;
(
  input  logic [7:0] opc_byte,
  input  logic [2:0] modrm_reg,
  input  logic       opsize_pfx,
  output dec_t       dec
);
  logic imm_ok;
  assign imm_ok = (modrm_reg == IMM_SUBOP);

  always_comb begin
    dec.legal   = 1'b0;
    dec.use_imm = 1'b0;
    dec.wide    = opsize_pfx;
    dec.lane    = LANE16;
    case (opc_byte)
      OPC_R16: begin dec.legal = 1'b1; dec.lane = LANE16; end
      OPC_R32: begin dec.legal = 1'b1; dec.lane = LANE32; end
      OPC_R64: begin dec.legal = 1'b1; dec.lane = LANE64; end
      OPC_I16: begin dec.legal = imm_ok; dec.use_imm = 1'b1; dec.lane = LANE16; end
      OPC_I32: begin dec.legal = imm_ok; dec.use_imm = 1'b1; dec.lane = LANE32; end
      OPC_I64: begin dec.legal = imm_ok; dec.use_imm = 1'b1; dec.lane = LANE64; end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vshl_lane.sv
module vshl_lane #(
  parameter int W  = 16,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  assign dout = din << amt;
endmodule

// File: rtl/vshl_core.sv
module vshl_core
  import vshl_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  input  dec_t              dec,
  output logic [DATA_W-1:0] dout
);
  logic [NUM_SIZES-1:0][DATA_W-1:0] by_size;
  logic [NUM_SIZES-1:0]             over;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = MIN_LANE << s;
    localparam int NL = DATA_W / LW;
    localparam int AW = $clog2(LW);
    // the full count takes part: any bit at or above AW means out of range
    assign over[s] = (cnt >> AW) != '0;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      vshl_lane #(.W(LW)) u_lane (
        .din  (din[l*LW +: LW]),
        .amt  (cnt[AW-1:0]),
        .dout (by_size[s][l*LW +: LW])
      );
    end
  end

  logic [DATA_W-1:0] picked;
  logic              zap;
  always_comb begin
    picked = by_size[dec.lane];
    zap    = !dec.legal || over[dec.lane];
    dout   = zap ? '0 : picked;
    if (!dec.wide) dout[DATA_W-1:HALF_W] = '0;
  end
endmodule

// File: rtl/vec_lshift_unit.sv
module vec_lshift_unit
  import vshl_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int CNT_W   = 64,
  parameter int IMM_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opc_byte,
  input  logic [2:0]        modrm_reg,
  input  logic              opsize_pfx,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count_reg,
  input  logic [IMM_W-1:0]  count_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  dec_t              dec;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shifted;

  vshl_decode u_dec (
    .opc_byte   (opc_byte),
    .modrm_reg  (modrm_reg),
    .opsize_pfx (opsize_pfx),
    .dec        (dec)
  );

  assign cnt = dec.use_imm ? {{(CNT_W-IMM_W){1'b0}}, count_imm} : count_reg;

  vshl_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .din  (operand),
    .cnt  (cnt),
    .dec  (dec),
    .dout (shifted)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        result    <= '0;
        illegal   <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result  <= shifted;
          illegal <= !dec.legal;
        end
      end
    end

    assert_reset_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0 && !illegal));
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));
    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && illegal) |-> result == '0);
    assert_narrow_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !opsize_pfx) |=> result[DATA_W-1:HALF_W] == '0);
    assert_regcount_over_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dec.use_imm && (count_reg >> 6) != '0) |=> result == '0);
    assert_imm_over_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec.use_imm && count_imm[IMM_W-1:6] != '0) |=> result == '0);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = shifted;
    assign illegal   = !dec.legal;
  end
endmodule

// File: tb/sim_vec_lshift_unit.sv
`timescale 1ns/1ps
module sim_vec_lshift_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   opc_byte = 8'h00;
  logic [2:0]   modrm_reg = 3'd0;
  logic         opsize_pfx = 1'b0;
  logic [127:0] operand = '0;
  logic [63:0]  count_reg = '0;
  logic [7:0]   count_imm = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  vec_lshift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opc_byte(opc_byte),
    .modrm_reg(modrm_reg), .opsize_pfx(opsize_pfx), .operand(operand),
    .count_reg(count_reg), .count_imm(count_imm), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  localparam logic [127:0] PAT_A = 128'h8001_7FFF_1234_FFFF_0001_A5A5_C3C3_0F0F;
  localparam logic [127:0] PAT_B = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
  localparam int NV = 12;
  // {opc[8], reg[3], pfx[1], operand[128], count_reg[64], count_imm[8]}
  localparam logic [211:0] TBL [NV] = '{
    {8'hF1, 3'd0, 1'b1, PAT_A, 64'd4,  8'd0},
    {8'hF2, 3'd0, 1'b1, PAT_A, 64'd8,  8'd0},
    {8'hF3, 3'd0, 1'b1, PAT_B, 64'd1,  8'd0},
    {8'hF3, 3'd0, 1'b0, PAT_B, 64'd63, 8'd0},
    {8'h71, 3'd6, 1'b0, PAT_A, 64'd0,  8'd15},
    {8'h72, 3'd6, 1'b1, PAT_B, 64'd0,  8'd31},
    {8'h73, 3'd6, 1'b1, PAT_B, 64'd0,  8'd32},
    {8'hF1, 3'd0, 1'b1, PAT_A, 64'd16, 8'd0},
    {8'hF2, 3'd0, 1'b1, PAT_B, 64'h0000_0001_0000_0001, 8'd0},
    {8'h71, 3'd6, 1'b1, PAT_A, 64'd0,  8'hC0},
    {8'hF3, 3'd0, 1'b1, PAT_B, 64'd0,  8'd0},
    {8'h72, 3'd5, 1'b1, PAT_B, 64'd2,  8'd3}
  };

  // reference: bit-by-bit, from the requirements
  function automatic logic [128:0] model(input logic [7:0] o, input logic [2:0] r,
      input logic p, input logic [127:0] a, input logic [63:0] cr, input logic [7:0] ci);
    int lw;
    bit imm;
    bit ok;
    logic [63:0] c;
    logic [127:0] res;
    lw = 0; imm = 0; ok = 1; res = '0;
    case (o)
      8'hF1: lw = 16;
      8'hF2: lw = 32;
      8'hF3: lw = 64;
      8'h71: begin lw = 16; imm = 1; end
      8'h72: begin lw = 32; imm = 1; end
      8'h73: begin lw = 64; imm = 1; end
      default: ok = 0;
    endcase
    if (imm && r != 3'd6) ok = 0;
    c = imm ? {56'd0, ci} : cr;
    if (ok && c < 64'(lw)) begin
      for (int i = 0; i < (p ? 128 : 64); i++) begin
        int pos;
        pos = i % lw;
        if (pos >= int'(c)) res[i] = a[i - int'(c)];
      end
    end
    return {!ok, res};
  endfunction

  task automatic check(input string tag, input logic [128:0] got, input logic [128:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got illegal=%0b result=%h, expected illegal=%0b result=%h",
               tag, got[128], got[127:0], exp[128], exp[127:0]);
    end
  endtask

  task automatic run(input logic [211:0] v, input string tag);
    @(negedge clk);
    opc_byte = v[211:204]; modrm_reg = v[203:201]; opsize_pfx = v[200];
    operand = v[199:72]; count_reg = v[71:8]; count_imm = v[7:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {128'd0, out_valid}, {128'd0, 1'b1});
    check(tag, {illegal, result}, model(v[211:204], v[203:201], v[200], v[199:72], v[71:8], v[7:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 reset", {illegal, result}, 129'd0);
    check("R9 reset valid", {128'd0, out_valid}, 129'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      run(TBL[k], $sformatf("table vector %0d (R1 R2 R3 R4 R5 R6 R7)", k));
    end

    // R3: boundary count 15 vs 16 on 16-bit lanes
    run({8'hF1, 3'd0, 1'b1, PAT_B, 64'd15, 8'd0}, "R3 count 15 on 16-bit lanes");
    check("R3 lane top bit", {1'b0, result}, {1'b0, {8{1'b1, 15'd0}} & {8{16'h8000}} & (PAT_B << 15)});
    run({8'hF1, 3'd0, 1'b1, PAT_B, 64'd16, 8'd0}, "R3 count 16 on 16-bit lanes");
    // R5: immediate 64 on 64-bit lanes, and immediate form with wrong reg field
    run({8'h73, 3'd6, 1'b1, PAT_B, 64'd0, 8'd64}, "R5 immediate 64");
    run({8'h73, 3'd0, 1'b1, PAT_B, 64'd0, 8'd1}, "R5 wrong reg field");
    // R4: high count bit only
    run({8'hF3, 3'd0, 1'b1, PAT_A, 64'h8000_0000_0000_0000, 8'd0}, "R4 top count bit");
    // R7: unknown opcode
    run({8'h70, 3'd6, 1'b1, PAT_A, 64'd1, 8'd1}, "R7 opcode 0x70");
    // R6: upper operand half ignored in 64-bit mode
    run({8'hF2, 3'd0, 1'b0, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0001, 64'd4, 8'd0},
        "R6 narrow upper ignored");
    check("R6 narrow value", {1'b0, result}, {1'b0, 128'h10});
    // R8: hold while idle
    run({8'hF1, 3'd0, 1'b1, PAT_A, 64'd1, 8'd0}, "R8 load");
    @(negedge clk);
    operand = '0; opc_byte = 8'h00;
    repeat (2) @(negedge clk);
    check("R8 idle valid", {128'd0, out_valid}, 129'd0);
    check("R8 hold", {illegal, result}, {1'b0, PAT_A << 1 & {8{16'hFFFE}}});
    // R9: reset mid-run
    run({8'hF3, 3'd0, 1'b1, PAT_B, 64'd2, 8'd0}, "R9 pre-reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears", {illegal, result}, 129'd0);
    check("R9 reset clears valid", {128'd0, out_valid}, 129'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule